// File: doc/BRIEF.md
# Frequency-Locked Trim Controller for a Ring Oscillator

This block closes a frequency-only control loop around a trimmable ring oscillator. It makes no phase comparison. A free-running Gray-coded counter in the oscillator domain counts oscillator rising edges. That count is synchronised into the reference domain and differenced over a fixed window of reference-clock cycles. At the end of each window the measured count is compared with a programmed target. A single trim step index then moves one step toward the target.

The index runs from 0 to 3·N, where N is the number of ring stages. It is expanded into one 3-bit thermometer field per stage, so each index step switches exactly one delay element in or out. Once settled, the index alternates between the two adjacent settings whose periods bracket the target period. The share of windows spent on each setting makes the mean frequency match the target, and the one-element gap between them bounds the cycle-to-cycle jitter.

A lock flag reports that the index has stayed inside one adjacent pair for a programmable number of consecutive windows. Dropping the enable parks the loop at mid-range.

Top module: `fll_trim_ctrl`

## Requirements
- R1: While `rst_n` is low, the step index sits at mid-range ((3·N)/2, which is 6 for N=4) and `lock_o` is low.
- R2: The measured count is the number of oscillator rising edges between two reference edges WINDOW cycles apart. After the 2-stage synchroniser, the loop acts on it only on the last reference cycle of each window.
- R3: At a window end, a count above `target_i` raises the index by one (more delay, because the oscillator is too fast). A count below `target_i` lowers it by one. An equal count leaves it unchanged.
- R4: The index saturates at 0 and at 3·N. A demand past either end leaves the index where it is.
- R5: `trim_o` has bits [3s+2:3s] as the field of stage s. In the default stage-by-stage fill, bit j is set exactly when the index is greater than j. The number of set bits always equals the index.
- R6: `trim_o` changes only on a window-end cycle or on leaving enable, and a window-end change flips exactly one bit.
- R7: `lock_o` is high when the band counter is nonzero and at least `lock_len_i`. The band counter saturates at 15, counts consecutive windows whose new index lies in the current adjacent pair {lo, lo+1}, and clears when a window leaves the pair. When that happens the pair is re-anchored at the lower of the old and new index.
- R8: With a constant target lying between two adjacent settings, the index settles into alternating between exactly those two settings.
- R9: While `en_i` is low, the index is held at mid-range, the window counter restarts, the pair anchor returns to mid-range, and `lock_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; all loop state is clocked by it |
| osc_clk | input | 1 | Ring-oscillator output being measured |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| en_i | input | 1 | Loop enable; low parks the index at mid-range |
| target_i | input | CNT_W (10) | Target oscillator edges per window |
| lock_len_i | input | LOCK_W (4) | Consecutive in-pair windows needed for lock |
| trim_o | output | 3·N_STAGES (12) | Per-stage thermometer trim fields |
| lock_o | output | 1 | Frequency lock indication |

## Verification
The hardest state to reach from the ports is a loop that is dithering and locked and that must then be pulled off its pair. It has to be driven there by a closed loop rather than by forcing values. The bench therefore models the oscillator behaviourally, with a half period that grows with the number of set trim bits. Its edges fall on odd picoseconds, so the edge count in each window is exact. Targets are chosen to land between adjacent settings, beyond both ends of the range, and then moved while locked. This covers dithering, both saturations and the loss of lock.

// File: rtl/fll_pkg.sv
`timescale 1ps/1ps
package fll_pkg;
   // how the step index is spread over the stage fields
   typedef enum logic {
      FILL_STAGE = 1'b0,   // fill stage 0 completely, then stage 1, ...
      FILL_ROUND = 1'b1    // one element per stage in turn
   } fill_e;

   localparam int ELEMS_PER_STAGE = 3;
endpackage

// File: rtl/fll_osc_count.sv
`timescale 1ps/1ps
module fll_osc_count #(
   parameter int W = 10
) (
   input  logic         osc_clk,
   input  logic         rst_n,
   output logic [W-1:0] gray_o
);
   logic [W-1:0] bin_q;
   logic [W-1:0] bin_nx;

   assign bin_nx = bin_q + W'(1);

   always_ff @(posedge osc_clk or negedge rst_n) begin
      if (!rst_n) begin
         bin_q  <= '0;
         gray_o <= '0;
      end else begin
         bin_q  <= bin_nx;
         gray_o <= bin_nx ^ (bin_nx >> 1);
      end
   end
endmodule

// File: rtl/fll_sync.sv
`timescale 1ps/1ps
module fll_sync #(
   parameter int W      = 10,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] pipe_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) pipe_q[i] <= '0;
      end else begin
         pipe_q[0] <= d_i;
         for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
      end
   end

   assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/fll_loop.sv
`timescale 1ps/1ps
module fll_loop #(
   parameter int CNT_W  = 10,
   parameter int WINDOW = 32,
   parameter int LOCK_W = 4,
   parameter int IDX_W  = 4,
   parameter int MAXI   = 12,
   parameter int MID    = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic [CNT_W-1:0]  cnt_i,
   input  logic [CNT_W-1:0]  tgt_i,
   input  logic [LOCK_W-1:0] lock_len_i,
   output logic [IDX_W-1:0]  idx_o,
   output logic              win_end_o,
   output logic              lock_o
);
   localparam int WIN_W = (WINDOW > 1) ? $clog2(WINDOW) : 1;
   localparam logic [IDX_W-1:0]  IDX_MAX = IDX_W'(MAXI);
   localparam logic [IDX_W-1:0]  IDX_MID = IDX_W'(MID);
   localparam logic [WIN_W-1:0]  WIN_LST = WIN_W'(WINDOW - 1);
   localparam logic [LOCK_W-1:0] RUN_TOP = '1;

   logic [WIN_W-1:0]  win_q;
   logic [CNT_W-1:0]  last_q;
   logic [IDX_W-1:0]  idx_q, band_q, idx_nx;
   logic [LOCK_W-1:0] run_q;
   logic [CNT_W-1:0]  meas;
   logic              in_band;

   assign win_end_o = en_i && (win_q == WIN_LST);

   always_comb begin
      meas   = cnt_i - last_q;
      idx_nx = idx_q;
      if (meas > tgt_i && idx_q != IDX_MAX)
         idx_nx = idx_q + IDX_W'(1);
      else if (meas < tgt_i && idx_q != '0)
         idx_nx = idx_q - IDX_W'(1);
      in_band = ({1'b0, idx_nx} == {1'b0, band_q}) ||
                ({1'b0, idx_nx} == ({1'b0, band_q} + (IDX_W+1)'(1)));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_q  <= '0;
         last_q <= '0;
         idx_q  <= IDX_MID;
         band_q <= IDX_MID;
         run_q  <= '0;
      end else if (!en_i) begin
         win_q  <= '0;
         last_q <= cnt_i;
         idx_q  <= IDX_MID;
         band_q <= IDX_MID;
         run_q  <= '0;
      end else if (win_end_o) begin
         win_q  <= '0;
         last_q <= cnt_i;
         idx_q  <= idx_nx;
         if (in_band) begin
            if (run_q != RUN_TOP) run_q <= run_q + LOCK_W'(1);
         end else begin
            run_q  <= '0;
            band_q <= (idx_nx > idx_q) ? idx_q : idx_nx;
         end
      end else begin
         win_q <= win_q + WIN_W'(1);
      end
   end

   assign idx_o  = idx_q;
   assign lock_o = (run_q != '0) && (run_q >= lock_len_i);
endmodule

// File: rtl/fll_therm.sv
`timescale 1ps/1ps
module fll_therm
   import fll_pkg::*;
#(
   parameter int    N_STAGES = 4,
   parameter int    IDX_W    = 4,
   parameter fill_e FILL     = FILL_STAGE
) (
   input  logic [IDX_W-1:0]                      idx_i,
   output logic [ELEMS_PER_STAGE*N_STAGES-1:0]   trim_o
);
   for (genvar s = 0; s < N_STAGES; s++) begin : g_stage
      for (genvar b = 0; b < ELEMS_PER_STAGE; b++) begin : g_elem
         if (FILL == FILL_STAGE) begin : g_seq
            localparam int ORD = ELEMS_PER_STAGE * s + b;
            assign trim_o[ELEMS_PER_STAGE*s+b] = (idx_i > IDX_W'(ORD));
         end else begin : g_rr
            localparam int ORD = N_STAGES * b + s;
            assign trim_o[ELEMS_PER_STAGE*s+b] = (idx_i > IDX_W'(ORD));
         end
      end
   end
endmodule

// File: rtl/fll_trim_ctrl.sv
`timescale 1ps/1ps
module fll_trim_ctrl
   import fll_pkg::*;
#(
   parameter int    N_STAGES    = 4,
   parameter int    CNT_W       = 10,
   parameter int    WINDOW      = 32,
   parameter int    LOCK_W      = 4,
   parameter int    SYNC_STAGES = 2,
   parameter fill_e FILL        = FILL_STAGE
) (
   input  logic                          ref_clk,
   input  logic                          osc_clk,
   input  logic                          rst_n,
   input  logic                          en_i,
   input  logic [CNT_W-1:0]              target_i,
   input  logic [LOCK_W-1:0]             lock_len_i,
   output logic [3*N_STAGES-1:0]         trim_o,
   output logic                          lock_o
);
   localparam int MAXI  = ELEMS_PER_STAGE * N_STAGES;
   localparam int MID   = MAXI / 2;
   localparam int IDX_W = $clog2(MAXI + 1);

   if (N_STAGES < 1) begin : g_bad_stages
      $error("fll_trim_ctrl: N_STAGES must be at least 1");
   end
   if (WINDOW < 2) begin : g_bad_window
      $error("fll_trim_ctrl: WINDOW must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("fll_trim_ctrl: SYNC_STAGES must be at least 2");
   end
   if (CNT_W < 2 || LOCK_W < 1) begin : g_bad_width
      $error("fll_trim_ctrl: counter widths too small");
   end

   logic [CNT_W-1:0] gray_osc, gray_ref, bin_ref;
   logic [IDX_W-1:0] idx_w;
   logic             win_end_w;

   fll_osc_count #(.W(CNT_W)) u_cnt (
      .osc_clk (osc_clk),
      .rst_n   (rst_n),
      .gray_o  (gray_osc)
   );

   fll_sync #(.W(CNT_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (ref_clk),
      .rst_n (rst_n),
      .d_i   (gray_osc),
      .q_o   (gray_ref)
   );

   always_comb begin
      bin_ref[CNT_W-1] = gray_ref[CNT_W-1];
      for (int i = CNT_W - 2; i >= 0; i--) bin_ref[i] = bin_ref[i+1] ^ gray_ref[i];
   end

   fll_loop #(
      .CNT_W(CNT_W), .WINDOW(WINDOW), .LOCK_W(LOCK_W),
      .IDX_W(IDX_W), .MAXI(MAXI), .MID(MID)
   ) u_loop (
      .clk        (ref_clk),
      .rst_n      (rst_n),
      .en_i       (en_i),
      .cnt_i      (bin_ref),
      .tgt_i      (target_i),
      .lock_len_i (lock_len_i),
      .idx_o      (idx_w),
      .win_end_o  (win_end_w),
      .lock_o     (lock_o)
   );

   fll_therm #(.N_STAGES(N_STAGES), .IDX_W(IDX_W), .FILL(FILL)) u_therm (
      .idx_i  (idx_w),
      .trim_o (trim_o)
   );
endmodule

// File: rtl/fll_trim_ctrl_chk.sv
`timescale 1ps/1ps
module fll_trim_ctrl_chk #(
   parameter int N_STAGES = 4
) (
   input logic                  ref_clk,
   input logic                  rst_n,
   input logic                  en_i,
   input logic [3*N_STAGES-1:0] trim_o,
   input logic                  lock_o,
   input logic [$clog2(3*N_STAGES+1)-1:0] idx_w,
   input logic                  win_end_w
);
   localparam int MAXI = 3 * N_STAGES;
   localparam int MID  = MAXI / 2;

   p_range_r4: assert property (@(posedge ref_clk) disable iff (!rst_n)
      int'(idx_w) <= MAXI);

   p_count_r5: assert property (@(posedge ref_clk) disable iff (!rst_n)
      $countones(trim_o) == int'(idx_w));

   p_one_elem_r6: assert property (@(posedge ref_clk) disable iff (!rst_n)
      $past(en_i) |-> $countones(trim_o ^ $past(trim_o)) <= 1);

   p_when_r6: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (trim_o != $past(trim_o)) |-> ($past(win_end_w) || !$past(en_i)));

   p_lock_edge_r7: assert property (@(posedge ref_clk) disable iff (!rst_n)
      $rose(lock_o) |-> $past(win_end_w));

   p_park_r9: assert property (@(posedge ref_clk) disable iff (!rst_n)
      !en_i |=> (int'(idx_w) == MID && !lock_o));
endmodule

bind fll_trim_ctrl fll_trim_ctrl_chk #(.N_STAGES(N_STAGES)) u_chk (
   .ref_clk   (ref_clk),
   .rst_n     (rst_n),
   .en_i      (en_i),
   .trim_o    (trim_o),
   .lock_o    (lock_o),
   .idx_w     (idx_w),
   .win_end_w (win_end_w)
);

// File: tb/fll_trim_ctrl_bench.sv
`timescale 1ps/1ps
module fll_trim_ctrl_bench;
   localparam int N      = 4;
   localparam int CW     = 10;
   localparam int WIN    = 32;
   localparam int LW     = 4;
   localparam int MAXI   = 3 * N;
   localparam int MID    = MAXI / 2;

   logic          ref_clk = 1'b0;
   logic          osc_clk = 1'b0;
   logic          rst_n   = 1'b0;
   logic          en      = 1'b0;
   logic [CW-1:0] target  = CW'(125);
   logic [LW-1:0] lock_len = LW'(3);
   logic [3*N-1:0] trim;
   logic          lock;

   int tests = 0;
   int fails = 0;

   fll_trim_ctrl u_fll_trim_ctrl (
      .ref_clk    (ref_clk),
      .osc_clk    (osc_clk),
      .rst_n      (rst_n),
      .en_i       (en),
      .target_i   (target),
      .lock_len_i (lock_len),
      .trim_o     (trim),
      .lock_o     (lock)
   );

   // 125 MHz reference: 8000 ps period, edges on even picoseconds
   always #4000 ref_clk = ~ref_clk;

   // behavioural ring oscillator: longer half period for every enabled element,
   // started at 1 ps so its edges stay on odd picoseconds
   initial begin
      #1;
      forever begin
         osc_clk = 1'b1;
         #(800 + 40 * $countones(trim));
         osc_clk = 1'b0;
         #(800 + 40 * $countones(trim));
      end
   end

   int osc_edges = 0;
   always @(posedge osc_clk) if (rst_n) osc_edges++;

   // values seen by the design at each reference edge
   int           cap_cnt;
   logic         cap_en, cap_rst;
   logic [CW-1:0] cap_tgt;
   always @(posedge ref_clk) begin
      cap_cnt = osc_edges;
      cap_en  = en;
      cap_rst = rst_n;
      cap_tgt = target;
   end

   // reference model of the loop, advanced once per reference cycle
   logic [CW-1:0] m_p1 = '0, m_p2 = '0, m_last = '0, m_meas;
   int m_win = 0, m_idx = MID, m_band = MID, m_run = 0, m_nx;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   always @(negedge ref_clk) begin
      if (!cap_rst) begin
         m_p1 = '0; m_p2 = '0; m_last = '0;
         m_win = 0; m_idx = MID; m_band = MID; m_run = 0;
      end else begin
         if (!cap_en) begin
            m_win = 0; m_last = m_p2; m_idx = MID; m_band = MID; m_run = 0;
         end else if (m_win == WIN - 1) begin
            m_win  = 0;
            m_meas = m_p2 - m_last;
            m_last = m_p2;
            m_nx   = m_idx;
            if (m_meas > cap_tgt && m_idx < MAXI) m_nx = m_idx + 1;
            else if (m_meas < cap_tgt && m_idx > 0) m_nx = m_idx - 1;
            if (m_nx == m_band || m_nx == m_band + 1) begin
               if (m_run < 15) m_run++;
            end else begin
               m_run  = 0;
               m_band = (m_nx < m_idx) ? m_nx : m_idx;
            end
            m_idx = m_nx;
         end else begin
            m_win++;
         end
         m_p2 = m_p1;
         m_p1 = CW'(cap_cnt);
      end
      begin
         logic [3*N-1:0] exp_trim;
         bit exp_lock;
         for (int j = 0; j < 3 * N; j++) exp_trim[j] = (m_idx > j);
         exp_lock = (m_run != 0) && (m_run >= int'(lock_len));
         check(trim === exp_trim, "R2 R3 R5 R6 trim vs model", int'(trim), int'(exp_trim));
         check(lock === exp_lock, "R7 lock vs model", int'(lock), int'(exp_lock));
      end
   end

   task automatic windows(input int n);
      repeat (n * WIN) @(negedge ref_clk);
      #100;
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge ref_clk);
      #100;
      check(trim === 12'h03F, "R1 reset trim", int'(trim), 'h03F);
      check(lock === 1'b0, "R1 reset lock", int'(lock), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge ref_clk);
      #100;
      check($countones(trim) == MID, "R9 parked while disabled", $countones(trim), MID);

      // target between settings 5 and 6
      en = 1'b1;
      windows(40);
      check(lock === 1'b1, "R7 lock after settling", int'(lock), 1);
      begin
         bit seen5 = 0, seen6 = 0, other = 0;
         for (int k = 0; k < 12 * WIN; k++) begin
            @(negedge ref_clk); #100;
            if ($countones(trim) == 5) seen5 = 1;
            else if ($countones(trim) == 6) seen6 = 1;
            else other = 1;
         end
         check(seen5 && seen6 && !other, "R8 dither pair 5/6", {29'd0, seen5, seen6, other}, 6);
      end

      // move target while locked: lock must drop
      target = CW'(150);
      windows(3);
      check(lock === 1'b0, "R7 lock lost on target move", int'(lock), 0);
      windows(30);
      begin
         bit seen1 = 0, seen2 = 0, other = 0;
         for (int k = 0; k < 12 * WIN; k++) begin
            @(negedge ref_clk); #100;
            if ($countones(trim) == 1) seen1 = 1;
            else if ($countones(trim) == 2) seen2 = 1;
            else other = 1;
         end
         check(seen1 && seen2 && !other, "R8 dither pair 1/2", {29'd0, seen1, seen2, other}, 6);
      end

      // unreachable high target: floor saturation
      target = CW'(200);
      windows(20);
      check(trim === '0, "R4 saturate at 0", int'(trim), 0);
      windows(3);
      check(trim === '0, "R4 held at 0", int'(trim), 0);

      // unreachable low target: ceiling saturation
      target = CW'(90);
      windows(30);
      check(trim === 12'hFFF, "R4 saturate at top", int'(trim), 'hFFF);
      windows(3);
      check(trim === 12'hFFF, "R4 held at top", int'(trim), 'hFFF);

      // disable parks the loop
      @(negedge ref_clk); #100;
      en = 1'b0;
      @(negedge ref_clk); #100;
      check($countones(trim) == MID, "R9 disable to mid", $countones(trim), MID);
      check(lock === 1'b0, "R9 disable clears lock", int'(lock), 0);

      // re-enable: nothing moves before a full window
      target = CW'(125);
      lock_len = LW'(5);
      en = 1'b1;
      repeat (WIN - 1) @(negedge ref_clk);
      #100;
      check($countones(trim) == MID, "R2 no step inside window", $countones(trim), MID);
      windows(40);
      check(lock === 1'b1, "R7 relock with longer length", int'(lock), 1);

      summary();
   end

   initial begin
      repeat (150000) @(posedge ref_clk);
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end
endmodule